// File: doc/BRIEF.md
# Wait-Mode Wake-Up Sequencer

This block keeps a processor core clock-gated while it sleeps and brings it back when an enabled peripheral interrupt arrives. A request from the running core stops the core clock. The block then watches the interrupt lines. Each line has its own priority field. Only a line with a nonzero priority can wake the core, and a line set to priority zero is treated as switched off. No global interrupt-enable bit is involved in either going to sleep or waking.

Once a valid wake occurs, three phases run back to back.

- Regulator settling comes first. It lasts a fixed number of microseconds, but only when the low-power regulator option is set. Otherwise it takes no time.
- Flash activation comes next. It lasts one system-clock cycle, plus a fixed number of extra microseconds when flash was stopped during sleep.
- Clock restart comes last. It lasts two cycles of the selected core clock.

On exit, the block copies the wake clock-select field into the active divider select, re-enables the core clock and pulses a run strobe for one cycle. Microsecond delays come from one shared down-counter, scaled by a cycles-per-microsecond parameter.

Top module: `wake_seq`

## Requirements
- R1: After reset the core clock enable is 1, the run strobe is 0, the flash activation request is 0 and the divider select is 0.
- R2: A sleep request sampled while the core runs drops the core clock enable on the next cycle. The enable stays 0 until the wake sequence finishes.
- R3: While asleep, an interrupt line whose priority field is 0 has no effect. The clock enable and the flash request both stay 0.
- R4: With the low-power regulator option set, the flash request first shows STAB_US*CYC_PER_US+1 cycles after the edge that samples the wake interrupt. With the option clear, it shows 1 cycle after that edge.
- R5: The flash request stays high for 1 cycle when flash-stop is 0. It stays high for 1+FLASH_US*CYC_PER_US cycles when flash-stop is 1. The core clock enable is 0 throughout.
- R6: After the flash request falls, the clock enable stays 0 for 2<<S cycles, where S is the wake clock-select value (divide-by-2^S). It then returns to 1.
- R7: When the clock enable returns, the divider select equals the wake clock-select value. The divider select does not change while the core runs.
- R8: The run strobe is high for exactly one cycle, which is the first cycle in which the clock enable is back at 1.
- R9: Sleep requests made while waking have no effect on the phase timing. So do further interrupts arriving while waking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wait_req | input | 1 | Sleep request from the running core |
| irq_req | input | NUM_SRC | Peripheral interrupt request lines |
| irq_prio | input | NUM_SRC*PRIO_W | Per-line priority fields, line i at bits [i*PRIO_W +: PRIO_W] |
| flash_stop_cfg | input | 1 | Flash is stopped during sleep |
| lp_reg_cfg | input | 1 | Low-power regulator option enabled |
| wake_clk_sel | input | SEL_W | Divider select to apply on wake |
| cpu_clk_en | output | 1 | Core clock enable |
| flash_act_req | output | 1 | Flash activation in progress |
| clk_div_sel | output | SEL_W | Active core clock divider select |
| core_run | output | 1 | One-cycle strobe when the core resumes |

## Verification
The bench builds the block with CYC_PER_US set to 2. NUM_SRC, PRIO_W, SEL_W and the 100 µs and 60 µs phase lengths keep their defaults. This makes the longest settling phase 200 cycles and the longest flash phase 121 cycles. Every combination of regulator option and flash-stop can therefore be timed exactly to the cycle. Divider selects from 0 to 3 make the restart phase 2, 4, 8 and 16 cycles long.

// File: rtl/wake_pkg.sv
package wake_pkg;

   typedef enum logic [2:0] {
      ST_RUN     = 3'd0,
      ST_WAIT    = 3'd1,
      ST_PWR     = 3'd2,
      ST_FLASH   = 3'd3,
      ST_RESTART = 3'd4
   } wake_st_e;

   function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                        input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/wake_src_filter.sv
module wake_src_filter #(
   parameter int NUM_SRC = 4,
   parameter int PRIO_W  = 3
) (
   input  logic [NUM_SRC-1:0]        irq_req,
   input  logic [NUM_SRC*PRIO_W-1:0] irq_prio,
   output logic                      wake_hit
);

   logic [NUM_SRC-1:0] armed;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      assign armed[i] = irq_req[i] && (irq_prio[i*PRIO_W +: PRIO_W] != '0);
   end

   assign wake_hit = |armed;

endmodule

// File: rtl/wake_phase_timer.sv
module wake_phase_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);

endmodule

// File: rtl/wake_seq.sv
module wake_seq
   import wake_pkg::*;
#(
   parameter int NUM_SRC    = 4,
   parameter int PRIO_W     = 3,
   parameter int SEL_W      = 3,
   parameter int CYC_PER_US = 20,
   parameter int STAB_US    = 100,
   parameter int FLASH_US   = 60
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wait_req,
   input  logic [NUM_SRC-1:0]        irq_req,
   input  logic [NUM_SRC*PRIO_W-1:0] irq_prio,
   input  logic                      flash_stop_cfg,
   input  logic                      lp_reg_cfg,
   input  logic [SEL_W-1:0]          wake_clk_sel,
   output logic                      cpu_clk_en,
   output logic                      flash_act_req,
   output logic [SEL_W-1:0]          clk_div_sel,
   output logic                      core_run
);

   localparam int unsigned STAB_CYC  = STAB_US * CYC_PER_US;
   localparam int unsigned FLASH_CYC = 1 + FLASH_US * CYC_PER_US;
   localparam int unsigned RST_MAX   = 2 << ((1 << SEL_W) - 1);
   localparam int unsigned MAX_CYC   = max3(STAB_CYC, FLASH_CYC, RST_MAX);
   localparam int          CNT_W     = $clog2(MAX_CYC + 1);

   initial begin
      if (NUM_SRC < 1)    $error("NUM_SRC must be at least 1");
      if (PRIO_W < 1)     $error("PRIO_W must be at least 1");
      if (SEL_W < 1 || SEL_W > 4) $error("SEL_W must be 1..4");
      if (CYC_PER_US < 1) $error("CYC_PER_US must be at least 1");
   end

   wake_st_e         st;
   logic             wake_hit;
   logic             expired;
   logic             tmr_load;
   logic [CNT_W-1:0] tmr_val;
   logic             use_stab;
   logic [CNT_W-1:0] flash_len_m1;
   logic [CNT_W-1:0] rst_len_m1;

   wake_src_filter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_filter (
      .irq_req (irq_req),
      .irq_prio(irq_prio),
      .wake_hit(wake_hit)
   );

   wake_phase_timer #(.CNT_W(CNT_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (tmr_load),
      .load_val(tmr_val),
      .expired (expired)
   );

   if (STAB_CYC == 0) begin : g_no_stab
      assign use_stab = 1'b0;
   end else begin : g_stab
      assign use_stab = lp_reg_cfg;
   end

   assign flash_len_m1 = flash_stop_cfg ? CNT_W'(FLASH_CYC - 1) : '0;
   assign rst_len_m1   = (CNT_W'(2) << wake_clk_sel) - 1'b1;

   always_comb begin
      tmr_load = 1'b0;
      tmr_val  = '0;
      unique case (st)
         ST_WAIT: if (wake_hit) begin
            tmr_load = 1'b1;
            tmr_val  = use_stab ? CNT_W'(STAB_CYC - 1) : flash_len_m1;
         end
         ST_PWR: if (expired) begin
            tmr_load = 1'b1;
            tmr_val  = flash_len_m1;
         end
         ST_FLASH: if (expired) begin
            tmr_load = 1'b1;
            tmr_val  = rst_len_m1;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= ST_RUN;
         core_run    <= 1'b0;
         clk_div_sel <= '0;
      end else begin
         core_run <= 1'b0;
         unique case (st)
            ST_RUN:  if (wait_req) st <= ST_WAIT;
            ST_WAIT: if (wake_hit) st <= use_stab ? ST_PWR : ST_FLASH;
            ST_PWR:  if (expired) st <= ST_FLASH;
            ST_FLASH: if (expired) begin
               st          <= ST_RESTART;
               clk_div_sel <= wake_clk_sel;
            end
            ST_RESTART: if (expired) begin
               st       <= ST_RUN;
               core_run <= 1'b1;
            end
            default: st <= ST_RUN;
         endcase
      end
   end

   assign cpu_clk_en    = (st == ST_RUN);
   assign flash_act_req = (st == ST_FLASH);

endmodule

// File: rtl/wake_seq_chk.sv
module wake_seq_chk #(
   parameter int SEL_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wait_req,
   input logic             cpu_clk_en,
   input logic             flash_act_req,
   input logic [SEL_W-1:0] clk_div_sel,
   input logic             core_run
);

   // R2: clock gating only follows a sleep request
   a_r2_gate_after_req: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cpu_clk_en) |-> $past(wait_req));

   // R5: flash activation never overlaps a running core clock
   a_r5_flash_gated: assert property (@(posedge clk) disable iff (!rst_n)
      flash_act_req |-> !cpu_clk_en);

   // R7: divider select holds while the core runs
   a_r7_sel_held: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_clk_en && $past(cpu_clk_en)) |-> $stable(clk_div_sel));

   // R8: run strobe is one cycle wide
   a_r8_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
      core_run |=> !core_run);

   // R8: strobe coincides with clock re-enable
   a_r8_strobe_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_clk_en) |-> core_run);

   // R8: strobe only with the clock running
   a_r8_strobe_with_clk: assert property (@(posedge clk) disable iff (!rst_n)
      core_run |-> cpu_clk_en);

endmodule

bind wake_seq wake_seq_chk #(.SEL_W(SEL_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .wait_req     (wait_req),
   .cpu_clk_en   (cpu_clk_en),
   .flash_act_req(flash_act_req),
   .clk_div_sel  (clk_div_sel),
   .core_run     (core_run)
);

// File: tb/sim_wake_seq.sv
`timescale 1ns/1ps
module sim_wake_seq;

   localparam int NS  = 4;
   localparam int PW  = 3;
   localparam int SW  = 3;
   localparam int CYC = 2;
   localparam int STU = 100;
   localparam int FLU = 60;

   typedef struct {
      int fw;
      int rg;
      int sel;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wait_req = 1'b0;
   logic [NS-1:0] irq_req = '0;
   logic [NS*PW-1:0] irq_prio = '0;
   logic          flash_stop_cfg = 1'b0;
   logic          lp_reg_cfg = 1'b0;
   logic [SW-1:0] wake_clk_sel = '0;
   logic          cpu_clk_en;
   logic          flash_act_req;
   logic [SW-1:0] clk_div_sel;
   logic          core_run;

   int   n_chk = 0;
   int   n_bad = 0;
   exp_t expq[$];

   always #4 clk = ~clk;

   wake_seq #(.NUM_SRC(NS), .PRIO_W(PW), .SEL_W(SW), .CYC_PER_US(CYC),
              .STAB_US(STU), .FLASH_US(FLU)) u0 (
      .clk(clk), .rst_n(rst_n), .wait_req(wait_req), .irq_req(irq_req),
      .irq_prio(irq_prio), .flash_stop_cfg(flash_stop_cfg), .lp_reg_cfg(lp_reg_cfg),
      .wake_clk_sel(wake_clk_sel), .cpu_clk_en(cpu_clk_en),
      .flash_act_req(flash_act_req), .clk_div_sel(clk_div_sel), .core_run(core_run)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // monitor: measures flash width and restart gap, compares at clock re-enable
   int fw_m = 0, rg_m = 0;
   bit inseq = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (flash_act_req) begin
            fw_m++;
            inseq = 1;
         end else if (inseq && !cpu_clk_en) begin
            rg_m++;
         end else if (inseq && cpu_clk_en) begin
            if (expq.size() == 0) begin
               check("R5 unexpected wake", 1, 0);
            end else begin
               exp_t e;
               e = expq.pop_front();
               check("R5 flash width", fw_m, e.fw);
               check("R6 restart gap", rg_m, e.rg);
               check("R7 divider select", int'(clk_div_sel), e.sel);
               check("R8 run strobe at resume", int'(core_run), 1);
            end
            fw_m = 0; rg_m = 0; inseq = 0;
         end else if (core_run) begin
            check("R8 stray strobe", 1, 0);
         end
      end
   end

   task automatic enter_wait();
      @(negedge clk);
      wait_req = 1'b1;
      @(negedge clk);
      wait_req = 1'b0;
      check("R2 clock gated", int'(cpu_clk_en), 0);
   endtask

   task automatic wake(input int src, input bit lp, input bit fs, input int sel,
                       input bit noise);
      exp_t e;
      int   d;
      @(negedge clk);
      lp_reg_cfg     = lp;
      flash_stop_cfg = fs;
      wake_clk_sel   = SW'(sel);
      e.fw  = fs ? 1 + FLU * CYC : 1;
      e.rg  = 2 << sel;
      e.sel = sel;
      expq.push_back(e);
      irq_req[src] = 1'b1;
      @(negedge clk);
      irq_req[src] = 1'b0;
      d = 1;
      while (!flash_act_req && d < 1000) begin
         if (noise) begin
            wait_req = (d % 7 == 3);
            irq_req  = (d % 5 == 1) ? NS'(4'b1010) : '0;
         end
         @(negedge clk);
         d++;
      end
      wait_req = 1'b0;
      irq_req  = '0;
      check("R4 time to flash activation", d, lp ? STU * CYC + 1 : 1);
      d = 0;
      while (!cpu_clk_en && d < 1000) begin
         if (noise) begin
            wait_req = (d % 3 == 0);
            irq_req  = (d % 4 == 2) ? NS'(4'b0101) : '0;
         end
         @(negedge clk);
         d++;
      end
      wait_req = 1'b0;
      irq_req  = '0;
      @(negedge clk);
      check("R8 strobe cleared", int'(core_run), 0);
      check("R7 select held", int'(clk_div_sel), sel);
   endtask

   bit done = 0;
   initial begin
      #(8 * 200000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      // source i priority: 0->3, 1->1, 2->0 (disabled), 3->5
      irq_prio = {3'd5, 3'd0, 3'd1, 3'd3};
      repeat (3) @(negedge clk);
      check("R1 clk enable", int'(cpu_clk_en), 1);
      check("R1 strobe", int'(core_run), 0);
      check("R1 flash req", int'(flash_act_req), 0);
      check("R1 divider", int'(clk_div_sel), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      enter_wait();
      // R3: disabled source pulses
      irq_req[2] = 1'b1;
      repeat (20) @(negedge clk);
      irq_req[2] = 1'b0;
      check("R3 clk stays off", int'(cpu_clk_en), 0);
      check("R3 flash stays idle", int'(flash_act_req), 0);
      // R9: a second sleep request while asleep changes nothing
      wait_req = 1'b1;
      @(negedge clk);
      wait_req = 1'b0;
      wake(0, 1'b0, 1'b0, 1, 1'b0);

      enter_wait();
      wake(3, 1'b1, 1'b1, 3, 1'b1);   // R9: noise during phases

      enter_wait();
      wake(1, 1'b1, 1'b0, 0, 1'b0);

      enter_wait();
      wake(0, 1'b0, 1'b1, 2, 1'b1);

      repeat (3) @(negedge clk);
      check("R5 queue drained", expq.size(), 0);
      check("R2 clock running at end", int'(cpu_clk_en), 1);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule